// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. A synchronous enable, pulsed once per hundredth of a second, advances the hundredths field. Carries ripple upward through the chain within the same clock edge. Month lengths follow the current month and year, and leap years are handled.

The hour byte works in one of two formats. In 24-hour format it counts 00 to 23. In 12-hour format it counts 12, 01 … 11 and carries a PM flag. The day byte also holds two control bits. One stops the clock. The other masks an external active-low abort request.

The whole state is read as a single 64-bit word. It is written as a single 64-bit word in one clock cycle, and that write also clears the hundredths field. Fields that carry no information always read as zero.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the word reads 64'h0001_0131_0000_0000. This means 24-hour format at 00:00:00.00, day of week 1, date 01, month 01, year 00, with both control bits (day byte bits 5 and 4) set.
- R2: With the stop bit clear, each cycle with `tick_i` high advances hundredths by one. Hundredths wrap from 99 to 00 and carry into seconds, seconds wrap from 59 to 00 and carry into minutes, and minutes wrap from 59 to 00 and carry into hours.
- R3: While day byte bit 5 (stop bit) is 1, `tick_i` has no effect and every field holds its value.
- R4: When hour byte bit 7 is 0 (24-hour format), bits 5:4 form the BCD tens of the hour and bits 3:0 form the units, giving 00 to 23. A carry out of 23 returns the hour to 00 and advances the day.
- R5: When hour byte bit 7 is 1 (12-hour format), bit 5 is the PM flag, bit 4 is the tens and bits 3:0 are the units. The hour runs 12, 01 … 11. The step from 11 to 12 flips the PM flag, and only the step from 11 PM to 12 AM advances the day.
- R6: The day of week (day byte bits 2:0) runs 1 to 7 and returns to 1 on each day advance.
- R7: On a day advance the date (date byte bits 5:0) wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 (year 00 included) and 28 days otherwise. All other months have 31 days.
- R8: A month advance out of month 12 (month byte bits 4:0) gives month 01 and increments the year, and year 99 wraps to 00.
- R9: A cycle with `load_i` high replaces every field from `load_word_i` on the next edge. Hundredths become 00 whatever value is loaded, and the load takes priority over a simultaneous tick. The byte order, from bit 0 upward, is hundredths, seconds, minutes, hours, day, date, month, year.
- R10: Unused bits always read 0, whatever value is loaded into them. These are seconds bit 7, minutes bit 7, hour bit 6, day bits 7, 6 and 3, date bits 7:6, and month bits 7:5.
- R11: `xfer_abort_o` is high exactly when `ext_rst_n_i` is low and the mask bit (day byte bit 4) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable per hundredth of a second |
| load_i | input | 1 | Load the whole time word this cycle |
| load_word_i | input | 64 | Time word to load |
| ext_rst_n_i | input | 1 | External active-low abort request |
| time_word_o | output | 64 | Current time word |
| xfer_abort_o | output | 1 | Abort request after masking |

## Verification
The bench starts from loaded times just before each rollover. These cover a full day in both hour formats, the 11-to-12 PM flip, and month ends for 30- and 31-day months. They also cover February in leap years, in year 00 and in common years, and the year 99 to 00 wrap. A wrong leap rule or month table shows up as a date of 29, 30 or 31 that should not exist, or as a missed month advance. A 12-hour counter that carried on the wrong edge would change the day at noon or leave the PM flag unflipped. The bench also loads words with every unused bit set and a nonzero hundredths value while a tick is present. An unmasked load or a tick that won over the load would then show up directly in the read word.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 8;
  localparam int WORD_W  = BYTE_W * N_BYTES;

  localparam int F_HUND  = 0;
  localparam int F_SEC   = 1;
  localparam int F_MIN   = 2;
  localparam int F_HOUR  = 3;
  localparam int F_DAY   = 4;
  localparam int F_DATE  = 5;
  localparam int F_MONTH = 6;
  localparam int F_YEAR  = 7;

  // bit positions inside the day byte
  localparam int DAY_STOP_BIT = 5;
  localparam int DAY_MASK_BIT = 4;

  localparam logic [WORD_W-1:0] USED_MASK  = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [WORD_W-1:0] RESET_WORD = 64'h0001_0131_0000_0000;

  // add one to a two-digit BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: tens parity contributes 0 or 2 to the residue
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {1'b0, yr[3:0]} + (yr[4] ? 5'd2 : 5'd0);
    return (s[1:0] == 2'b00);
  endfunction

  // last date of a month, in BCD
  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter
  import rtc_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FIRST = 8'h00,
  parameter logic [BYTE_W-1:0] LAST  = 8'h99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              wrap_o
);
  logic [BYTE_W-1:0] cnt_q;
  logic              at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = step_i & at_last & ~load_i;
  assign val_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= FIRST;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= at_last ? FIRST : bcd_inc(cnt_q);
  end

  // R2: count stays a valid BCD value inside its range
  assert_bcd_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[3:0] <= 4'd9) && (cnt_q <= LAST));

  // R2: a wrap returns the count to its first value
  assert_wrap_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (val_o == FIRST));
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       load_i,
  input  logic [6:0] load_hour_i,   // {format, bits 5:0 of the hour byte}
  output logic [7:0] hour_byte_o,
  output logic       day_carry_o
);
  logic       fmt12_q, pm_q;
  logic [5:0] hr_q, hr_n;
  logic       pm_n;
  logic       at_11, at_12, at_23;

  assign at_11 = (hr_q == 6'h11);
  assign at_12 = (hr_q == 6'h12);
  assign at_23 = (hr_q == 6'h23);

  assign day_carry_o = step_i & ~load_i & (fmt12_q ? (at_11 & pm_q) : at_23);

  always_comb begin
    hr_n = hr_q;
    pm_n = pm_q;
    if (fmt12_q) begin
      if (at_12) hr_n = 6'h01;
      else if (at_11) begin
        hr_n = 6'h12;
        pm_n = ~pm_q;
      end else hr_n = 6'(rtc_cal_pkg::bcd_inc({2'b00, hr_q}));
    end else begin
      hr_n = at_23 ? 6'h00 : 6'(rtc_cal_pkg::bcd_inc({2'b00, hr_q}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt12_q <= 1'b0;
      pm_q    <= 1'b0;
      hr_q    <= 6'h00;
    end else if (load_i) begin
      fmt12_q <= load_hour_i[6];
      pm_q    <= load_hour_i[6] & load_hour_i[5];
      hr_q    <= load_hour_i[6] ? {1'b0, load_hour_i[4:0]} : load_hour_i[5:0];
    end else if (step_i) begin
      hr_q <= hr_n;
      pm_q <= pm_n;
    end
  end

  assign hour_byte_o = fmt12_q ? {1'b1, 1'b0, pm_q, hr_q[4:0]} : {2'b00, hr_q};

  // R5: 12-hour format keeps 01..12
  assert_hour12_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fmt12_q |-> (hr_q != 6'h00) && (hr_q <= 6'h12) && (hr_q[3:0] <= 4'd9));

  // R5: step out of 11 flips the PM flag
  assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && fmt12_q && at_11) |=> (pm_q != $past(pm_q)));

  // R4: 24-hour format keeps 00..23 with no PM flag
  assert_hour24_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt12_q |-> (hr_q <= 6'h23) && (hr_q[3:0] <= 4'd9) && !pm_q);
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       load_i,
  input  logic [2:0] load_dow_i,
  input  logic [5:0] load_date_i,
  input  logic [4:0] load_month_i,
  input  logic [7:0] year_i,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic       year_step_o
);
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] month_q;
  logic [5:0] last_date;
  logic       month_end, year_end;

  assign last_date   = month_len(month_q, year_i);
  assign month_end   = (date_q >= last_date);
  assign year_end    = (month_q == 5'h12);
  assign year_step_o = step_i & ~load_i & month_end & year_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q   <= 3'd1;
      date_q  <= 6'h01;
      month_q <= 5'h01;
    end else if (load_i) begin
      dow_q   <= load_dow_i;
      date_q  <= load_date_i;
      month_q <= load_month_i;
    end else if (step_i) begin
      dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      date_q <= month_end ? 6'h01 : 6'(bcd_inc({2'b00, date_q}));
      if (month_end)
        month_q <= year_end ? 5'h01 : 5'(bcd_inc({3'b000, month_q}));
    end
  end

  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;

  // R7: date never passes the length of its month
  assert_date_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (date_q != 6'h00) && (date_q <= last_date));

  // R6: day of week stays 1..7
  assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_q != 3'd0));

  // R8: leaving December lands on January
  assert_month_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    year_step_o |=> (month_q == 5'h01) && (date_q == 6'h01));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        load_i,
  input  logic [63:0] load_word_i,
  input  logic        ext_rst_n_i,
  output logic [63:0] time_word_o,
  output logic        xfer_abort_o
);
  localparam int N_LOW = 3;  // hundredths, seconds, minutes

  logic              stop_q, mask_q;
  logic              adv_hund;
  logic [N_LOW:0]    chain_step;
  logic [BYTE_W-1:0] low_val [N_LOW];
  logic [7:0]        hour_byte, year_val;
  logic              day_step, year_step;
  logic [2:0]        dow;
  logic [5:0]        date;
  logic [4:0]        month;

  assign adv_hund      = tick_i & ~stop_q;
  assign chain_step[0] = adv_hund;

  generate
    for (genvar i = 0; i < N_LOW; i++) begin : g_low
      localparam logic [7:0] LAST_I = (i == 0) ? 8'h99 : 8'h59;
      logic [7:0] ld_val;
      if (i == F_HUND) begin : g_clr
        assign ld_val = 8'h00;
      end else begin : g_ld
        assign ld_val = {1'b0, load_word_i[BYTE_W*i +: 7]};
      end
      rtc_bcd_counter #(.FIRST(8'h00), .LAST(LAST_I)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(chain_step[i]), .load_i(load_i),
        .load_val_i(ld_val), .val_o(low_val[i]), .wrap_o(chain_step[i+1])
      );
    end
  endgenerate

  rtc_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .step_i(chain_step[N_LOW]), .load_i(load_i),
    .load_hour_i({load_word_i[BYTE_W*F_HOUR+7], load_word_i[BYTE_W*F_HOUR +: 6]}),
    .hour_byte_o(hour_byte), .day_carry_o(day_step)
  );

  rtc_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .step_i(day_step), .load_i(load_i),
    .load_dow_i(load_word_i[BYTE_W*F_DAY +: 3]),
    .load_date_i(load_word_i[BYTE_W*F_DATE +: 6]),
    .load_month_i(load_word_i[BYTE_W*F_MONTH +: 5]),
    .year_i(year_val), .dow_o(dow), .date_o(date), .month_o(month),
    .year_step_o(year_step)
  );

  rtc_bcd_counter #(.FIRST(8'h00), .LAST(8'h99)) u_year (
    .clk(clk), .rst_n(rst_n), .step_i(year_step), .load_i(load_i),
    .load_val_i(load_word_i[BYTE_W*F_YEAR +: 8]), .val_o(year_val), .wrap_o()
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      mask_q <= 1'b1;
    end else if (load_i) begin
      stop_q <= load_word_i[BYTE_W*F_DAY + DAY_STOP_BIT];
      mask_q <= load_word_i[BYTE_W*F_DAY + DAY_MASK_BIT];
    end
  end

  assign time_word_o = {year_val, 3'b000, month, 2'b00, date,
                        2'b00, stop_q, mask_q, 1'b0, dow,
                        hour_byte, low_val[F_MIN], low_val[F_SEC], low_val[F_HUND]};

  assign xfer_abort_o = ~ext_rst_n_i & ~mask_q;

  // R3: stop bit freezes the whole word
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (time_word_o[BYTE_W*F_DAY + DAY_STOP_BIT] && !load_i) |=> $stable(time_word_o));

  // R10: unused bits read zero
  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (time_word_o & ~USED_MASK) == 64'h0);

  // R9: load replaces every used field and clears hundredths
  assert_load_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> time_word_o == (($past(load_word_i) & USED_MASK) & ~64'hFF));

  // R11: masked request never reaches the output
  assert_abort_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (time_word_o[BYTE_W*F_DAY + DAY_MASK_BIT] || ext_rst_n_i) |-> !xfer_abort_o);
endmodule

// File: tb/rtc_bcd_calendar_bench.sv
module rtc_bcd_calendar_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] load_word_i = '0;
  logic        ext_rst_n_i = 1'b1;
  logic [63:0] time_word_o;
  logic        xfer_abort_o;

  always #4 clk = ~clk;

  rtc_bcd_calendar u_rtc_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .load_word_i(load_word_i), .ext_rst_n_i(ext_rst_n_i),
    .time_word_o(time_word_o), .xfer_abort_o(xfer_abort_o)
  );

  // behavioural reference state; hour kept as 0..23 in both formats
  int m_hund, m_sec, m_min, m_h, m_dow, m_date, m_mon, m_year;
  bit m_fmt12, m_stop, m_mask;
  int n_cmp = 0, n_bad = 0;
  bit checking = 1'b0;
  string cur_req = "R1";

  localparam logic [63:0] JUNK = 64'h00E0_C0C8_4080_8000;

  function automatic int dim(int mo, int yr);
    case (mo)
      2: return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] b2(int x);
    return 8'((x / 10) * 16 + (x % 10));
  endfunction

  function automatic int d2(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [63:0] mk(int hu, int se, int mi, int h, bit f12,
                                     int dw, int dt, int mo, int yr, bit st, bit mk_);
    logic [7:0] hb, tmp;
    int h12;
    if (f12) begin
      h12 = (h % 12 == 0) ? 12 : h % 12;
      tmp = b2(h12);
      hb = {1'b1, 1'b0, (h >= 12), tmp[4:0]};
    end else hb = b2(h);
    return {b2(yr), b2(mo), b2(dt), {2'b00, st, mk_, 1'b0, 3'(dw)}, hb, b2(mi), b2(se), b2(hu)};
  endfunction

  function automatic logic [63:0] model_word();
    return mk(m_hund, m_sec, m_min, m_h, m_fmt12, m_dow, m_date, m_mon, m_year, m_stop, m_mask);
  endfunction

  task automatic model_load(logic [63:0] w);
    logic [7:0] hb;
    int hr;
    hb = w[31:24];
    m_hund = 0;
    m_sec  = d2({1'b0, w[14:8]});
    m_min  = d2({1'b0, w[22:16]});
    m_fmt12 = hb[7];
    if (hb[7]) begin
      hr  = d2({3'b000, hb[4:0]});
      m_h = (hr % 12) + (hb[5] ? 12 : 0);
    end else m_h = d2({2'b00, hb[5:0]});
    m_stop = w[37];
    m_mask = w[36];
    m_dow  = int'(w[34:32]);
    m_date = d2({2'b00, w[45:40]});
    m_mon  = d2({3'b000, w[52:48]});
    m_year = d2(w[63:56]);
  endtask

  task automatic model_advance();
    m_hund++;
    if (m_hund < 100) return;
    m_hund = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_dow = (m_dow % 7) + 1;
    m_date++;
    if (m_date <= dim(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1;
    m_year = (m_year + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hund = 0; m_sec = 0; m_min = 0; m_h = 0; m_fmt12 = 0;
      m_dow = 1; m_date = 1; m_mon = 1; m_year = 0; m_stop = 1; m_mask = 1;
    end else if (load_i) model_load(load_word_i);
    else if (tick_i && !m_stop) model_advance();
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [63:0] exp_w;
      logic        exp_a;
      exp_w = model_word();
      exp_a = !ext_rst_n_i && !m_mask;
      n_cmp++;
      if (time_word_o !== exp_w) begin
        n_bad++;
        $display("FAIL %s time word got %h expected %h", cur_req, time_word_o, exp_w);
      end
      n_cmp++;
      if (xfer_abort_o !== exp_a) begin
        n_bad++;
        $display("FAIL R11 abort got %b expected %b", xfer_abort_o, exp_a);
      end
    end
  end

  task automatic do_load(logic [63:0] w, bit with_tick);
    @(posedge clk); #2;
    load_i = 1'b1; load_word_i = w; tick_i = with_tick;
    @(posedge clk); #2;
    load_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic run(int n, bit every);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      tick_i = every ? 1'b1 : 1'($urandom % 2);
    end
    @(posedge clk); #2;
    tick_i = 1'b0;
  endtask

  task automatic scen(string req, logic [63:0] w, int n);
    cur_req = req;
    do_load(w, 1'b0);
    run(n, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired before completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (time_word_o !== 64'h0001_0131_0000_0000) begin
      n_bad++;
      $display("FAIL R1 reset word got %h expected %h", time_word_o, 64'h0001_0131_0000_0000);
    end
    checking = 1'b1;

    // R3: stop bit set from reset, ticks do nothing
    cur_req = "R3";
    run(40, 1'b1);
    // R11: mask set, low request is blocked
    cur_req = "R11";
    @(posedge clk); #2 ext_rst_n_i = 1'b0;
    run(4, 1'b0);

    // R2: second, minute and hour carries; mask now clear
    scen("R2", mk(0, 58, 0, 0, 0, 3, 10, 5, 21, 0, 0), 230);
    scen("R2", mk(0, 59, 59, 5, 0, 3, 10, 5, 21, 0, 0), 130);
    cur_req = "R11";
    @(posedge clk); #2 ext_rst_n_i = 1'b1;
    run(3, 1'b0);
    @(posedge clk); #2 ext_rst_n_i = 1'b0;
    run(3, 1'b0);
    @(posedge clk); #2 ext_rst_n_i = 1'b1;
    // R4: 24-hour tens into the 20s and midnight
    scen("R4", mk(0, 59, 59, 19, 0, 2, 14, 7, 33, 0, 1), 120);
    scen("R4", mk(0, 59, 59, 23, 0, 2, 14, 7, 33, 0, 1), 120);
    // R5: 12-hour flips and day carry
    scen("R5", mk(0, 59, 59, 11, 1, 4, 9, 3, 45, 0, 1), 120);
    scen("R5", mk(0, 59, 59, 12, 1, 4, 9, 3, 45, 0, 1), 120);
    scen("R5", mk(0, 59, 59, 23, 1, 4, 9, 3, 45, 0, 1), 120);
    scen("R5", mk(0, 59, 59, 0, 1, 4, 9, 3, 45, 0, 1), 120);
    // R6: day of week 7 to 1
    scen("R6", mk(0, 59, 59, 23, 0, 7, 5, 8, 50, 0, 1), 120);
    // R7: month lengths and leap rule
    scen("R7", mk(0, 59, 59, 23, 0, 1, 28, 2, 24, 0, 1), 120);
    scen("R7", mk(0, 59, 59, 23, 0, 1, 29, 2, 24, 0, 1), 120);
    scen("R7", mk(0, 59, 59, 23, 0, 1, 28, 2, 23, 0, 1), 120);
    scen("R7", mk(0, 59, 59, 23, 0, 1, 28, 2, 0, 0, 1), 120);
    scen("R7", mk(0, 59, 59, 23, 0, 1, 30, 4, 10, 0, 1), 120);
    scen("R7", mk(0, 59, 59, 23, 0, 1, 30, 1, 10, 0, 1), 120);
    // R8: December 31 of year 99
    scen("R8", mk(0, 59, 59, 23, 0, 6, 31, 12, 99, 0, 1), 120);
    scen("R8", mk(0, 59, 59, 23, 1, 6, 31, 12, 41, 0, 1), 120);
    // R9: load with a tick present and nonzero hundredths in the word
    cur_req = "R9";
    do_load(mk(55, 30, 20, 10, 0, 2, 3, 4, 5, 0, 1) | 64'h77, 1'b1);
    run(20, 1'b0);
    // R10: every unused bit set in the loaded word
    cur_req = "R10";
    do_load(mk(0, 12, 34, 16, 0, 5, 6, 7, 8, 0, 1) | JUNK, 1'b0);
    run(10, 1'b1);
    do_load(mk(0, 12, 34, 16, 1, 5, 6, 7, 8, 0, 1) | JUNK, 1'b1);
    run(10, 1'b1);
    // R3: stop loaded mid-run, ticks ignored
    cur_req = "R3";
    do_load(mk(0, 59, 59, 23, 0, 1, 31, 12, 99, 1, 1), 1'b0);
    run(150, 1'b1);

    // R7 and R8: random month ends with random tick patterns
    for (int s = 0; s < 40; s++) begin
      int yr, mo;
      yr = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      cur_req = (mo == 12) ? "R8" : "R7";
      do_load(mk(0, 59, 59, 23, 1'($urandom % 2), 1 + int'($urandom % 7),
                 dim(mo, yr), mo, yr, 0, 1'($urandom % 2)), 1'b0);
      run(110, 1'b1);
      run(60, 1'b0);
    end

    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule